// File: doc/BRIEF.md
# Multicycle Shared-Memory Processor Datapath

This block is the datapath of a 32-bit processor that runs each instruction over several short clock cycles. A single word-wide memory serves both instruction fetch and data access, and a single ALU is reused from one step to the next. In one cycle it advances the PC, in another it forms a branch target, and in a third it does the instruction's own arithmetic. Hidden registers carry values between steps: the instruction register, the memory data register, two operand registers loaded from the register file, and an ALU result register.

The datapath makes no decisions of its own. An external control state machine drives every select and enable on each cycle. The datapath reports the opcode and function fields of the held instruction, and the ALU zero flag, back to that controller. The block contains a small word-addressed memory model. A test environment fills it through a load port before it releases reset.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high `rst` clears the PC, the instruction register, both operand registers, the memory data register, the ALU result register and all 32 general registers to zero on the next rising edge.
- R2: The memory address is `alu_out` when `iord`=1 and `pc` when `iord`=0. The word index is taken from address bits [MEM_AW+1:2], and the higher bits are ignored. `mem_rdata` shows the addressed word combinationally.
- R3: The instruction register loads `mem_rdata` on an edge only when `ir_wr`=1, and otherwise keeps its value. `opcode` is its bits 31:26 and `funct` is its bits 5:0.
- R4: The memory data register loads `mem_rdata` on every edge, with no enable. A register write takes its data from the memory data register when `mem_to_reg`=1 and from the ALU result register when `mem_to_reg`=0.
- R5: On every edge, operand register A loads the general register numbered by instruction bits 25:21, and operand register B loads the one numbered by bits 20:16. Both read the register file as it stood before that edge.
- R6: ALU operand one is `pc` when `alu_src_a`=0 and register A when `alu_src_a`=1. ALU operand two is selected by `alu_src_b`: 0 selects register B, 1 selects the constant 4, 2 selects sign-extended bits 15:0, and 3 selects that value shifted left by 2.
- R7: `alu_op` selects the operation: 0 add, 1 subtract (one minus two), 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0). Codes 5 to 7 give 0. `zero` is 1 exactly when the current ALU result is 0.
- R8: The ALU result register captures the ALU result on every edge. `alu_out` shows it.
- R9: `pc` is written when `pc_wr`=1, or when `pc_wr_cond`=1 and `zero`=1. The written value is the ALU result when `pc_sel`=0 and the ALU result register when `pc_sel`=1. Otherwise `pc` holds.
- R10: When `reg_wr`=1, the register numbered by instruction bits 20:16 is written if `reg_dst`=0, and the one numbered by bits 15:11 is written if `reg_dst`=1.
- R11: General register 0 always reads as zero, and a write to it has no effect.
- R12: When `mem_wr`=1 and `ld_en`=0, operand register B is stored into the memory word at the R2 address.
- R13: When `ld_en`=1, `ld_data` is written to word `ld_addr`, and this takes priority over `mem_wr`. The load port works while `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iord | input | 1 | Memory address select: 0 selects the PC, 1 selects the ALU result register |
| mem_wr | input | 1 | Store operand B to memory |
| ir_wr | input | 1 | Instruction register load enable |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write qualified by `zero` |
| pc_sel | input | 1 | PC source: 0 selects the ALU result, 1 selects the ALU result register |
| alu_src_a | input | 1 | ALU operand one select |
| alu_src_b | input | 2 | ALU operand two select |
| alu_op | input | 3 | ALU operation code |
| reg_dst | input | 1 | Destination field select |
| mem_to_reg | input | 1 | Write-back data select |
| reg_wr | input | 1 | Register file write enable |
| ld_en | input | 1 | Memory load port enable |
| ld_addr | input | MEM_AW | Memory load port word index |
| ld_data | input | 32 | Memory load port data |
| opcode | output | 6 | Instruction register bits 31:26 |
| funct | output | 6 | Instruction register bits 5:0 |
| zero | output | 1 | ALU result equals zero |
| pc | output | 32 | Program counter |
| alu_out | output | 32 | ALU result register |
| mem_rdata | output | 32 | Word at the current memory address |

## Verification
`zero` and `mem_rdata` are combinational. They respond to a control change within the same cycle, so the bench checks them 1 ns after it drives the controls on a falling edge. `pc`, `alu_out`, `opcode` and `funct` change on the next rising edge, so they are compared at the following falling edge. Results that pass through two registers, such as a loaded word reaching a general register and then the ALU result register, are checked only after the exact chain of cycles that carries them. A cycle-accurate reference model in the bench tracks every hidden register. This lets directed instruction sequences and random control patterns be compared cycle by cycle.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RAW    = $clog2(NREG);
    localparam int IMM_W  = 16;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        SRCB_REG   = 2'd0,
        SRCB_FOUR  = 2'd1,
        SRCB_IMM   = 2'd2,
        SRCB_IMMSH = 2'd3
    } srcb_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] opa;
        logic [XLEN-1:0] opb;
        logic [XLEN-1:0] mdr;
        logic [XLEN-1:0] res;
    } dp_state_t;
endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [2:0]   op,
    output logic [W-1:0] result,
    output logic         is_zero
);
    always_comb begin
        unique case (alu_op_e'(op))
            ALU_ADD: result = in_a + in_b;
            ALU_SUB: result = in_a - in_b;
            ALU_AND: result = in_a & in_b;
            ALU_OR:  result = in_a | in_b;
            ALU_SLT: result = ($signed(in_a) < $signed(in_b)) ? W'(1) : '0;
            default: result = '0;
        endcase
    end

    assign is_zero = (result == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int N  = NREG,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_sel_a,
    input  logic [AW-1:0] rd_sel_b,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [W-1:0]  wr_val,
    output logic [W-1:0]  rd_val_a,
    output logic [W-1:0]  rd_val_b
);
    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == 0) begin : g_hardzero
            assign regs[i] = '0;
        end else begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    regs[i] <= '0;
                end else if (wr_en && (wr_sel == AW'(i))) begin
                    regs[i] <= wr_val;
                end
            end
        end
    end

    assign rd_val_a = regs[rd_sel_a];
    assign rd_val_b = regs[rd_sel_b];
endmodule

// File: rtl/mc_mem.sv
module mc_mem
    import mc_pkg::*;
#(
    parameter int W     = XLEN,
    parameter int WORDS = 256,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic [AW-1:0] acc_idx,
    input  logic          acc_we,
    input  logic [W-1:0]  acc_wdata,
    input  logic          fill_en,
    input  logic [AW-1:0] fill_idx,
    input  logic [W-1:0]  fill_data,
    output logic [W-1:0]  acc_rdata
);
    logic [W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            cells[fill_idx] <= fill_data;
        end else if (acc_we) begin
            cells[acc_idx] <= acc_wdata;
        end
    end

    assign acc_rdata = cells[acc_idx];
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    localparam int MEM_AW   = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iord,
    input  logic              mem_wr,
    input  logic              ir_wr,
    input  logic              pc_wr,
    input  logic              pc_wr_cond,
    input  logic              pc_sel,
    input  logic              alu_src_a,
    input  logic [1:0]        alu_src_b,
    input  logic [2:0]        alu_op,
    input  logic              reg_dst,
    input  logic              mem_to_reg,
    input  logic              reg_wr,
    input  logic              ld_en,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [5:0]        opcode,
    output logic [5:0]        funct,
    output logic              zero,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   alu_out,
    output logic [XLEN-1:0]   mem_rdata
);
    dp_state_t st_d, st_q;

    logic [XLEN-1:0]   addr_mux;
    logic [XLEN-1:0]   simm;
    logic [XLEN-1:0]   alu_in_a;
    logic [XLEN-1:0]   alu_in_b;
    logic [XLEN-1:0]   alu_res;
    logic              alu_zero;
    logic [XLEN-1:0]   rf_rd_a;
    logic [XLEN-1:0]   rf_rd_b;
    logic [RAW-1:0]    rf_wsel;
    logic [XLEN-1:0]   rf_wval;
    logic              pc_load;

    assign addr_mux = iord ? st_q.res : st_q.pc;
    assign simm     = {{(XLEN-IMM_W){st_q.ir[IMM_W-1]}}, st_q.ir[IMM_W-1:0]};
    assign alu_in_a = alu_src_a ? st_q.opa : st_q.pc;

    always_comb begin
        unique case (srcb_e'(alu_src_b))
            SRCB_REG:   alu_in_b = st_q.opb;
            SRCB_FOUR:  alu_in_b = XLEN'(4);
            SRCB_IMM:   alu_in_b = simm;
            SRCB_IMMSH: alu_in_b = {simm[XLEN-3:0], 2'b00};
            default:    alu_in_b = st_q.opb;
        endcase
    end

    mc_alu #(.W(XLEN)) u_alu (
        .in_a    (alu_in_a),
        .in_b    (alu_in_b),
        .op      (alu_op),
        .result  (alu_res),
        .is_zero (alu_zero)
    );

    assign rf_wsel = reg_dst ? st_q.ir[15:11] : st_q.ir[20:16];
    assign rf_wval = mem_to_reg ? st_q.mdr : st_q.res;

    mc_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_sel_a (st_q.ir[25:21]),
        .rd_sel_b (st_q.ir[20:16]),
        .wr_en    (reg_wr),
        .wr_sel   (rf_wsel),
        .wr_val   (rf_wval),
        .rd_val_a (rf_rd_a),
        .rd_val_b (rf_rd_b)
    );

    mc_mem #(.W(XLEN), .WORDS(MEM_WORDS)) u_mem (
        .clk       (clk),
        .acc_idx   (addr_mux[MEM_AW+1:2]),
        .acc_we    (mem_wr),
        .acc_wdata (st_q.opb),
        .fill_en   (ld_en),
        .fill_idx  (ld_addr),
        .fill_data (ld_data),
        .acc_rdata (mem_rdata)
    );

    assign pc_load = pc_wr | (pc_wr_cond & alu_zero);

    always_comb begin
        st_d     = st_q;
        st_d.ir  = ir_wr ? mem_rdata : st_q.ir;
        st_d.mdr = mem_rdata;
        st_d.opa = rf_rd_a;
        st_d.opb = rf_rd_b;
        st_d.res = alu_res;
        if (pc_load) begin
            st_d.pc = pc_sel ? st_q.res : alu_res;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign opcode  = st_q.ir[31:26];
    assign funct   = st_q.ir[5:0];
    assign zero    = alu_zero;
    assign pc      = st_q.pc;
    assign alu_out = st_q.res;
endmodule

// File: rtl/mc_datapath_chk.sv
module mc_datapath_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         pc_wr,
    input logic         pc_wr_cond,
    input logic         pc_sel,
    input logic         ir_wr,
    input logic         zero,
    input logic [5:0]   opcode,
    input logic [W-1:0] pc,
    input logic [W-1:0] alu_out,
    input logic [W-1:0] mem_rdata,
    input logic [W-1:0] alu_res
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc == '0 && alu_out == '0 && opcode == '0));

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr || (pc_wr_cond && zero)) |=> $stable(pc));

    // R9
    pc_from_alu_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && !pc_sel) |=> (pc == $past(alu_res)));

    // R9
    pc_from_reg_chk: assert property (@(posedge clk) disable iff (rst)
        ((pc_wr || (pc_wr_cond && zero)) && pc_sel) |=> (pc == $past(alu_out)));

    // R3
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ir_wr |=> $stable(opcode));

    // R3
    ir_load_chk: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (opcode == $past(mem_rdata[31:26])));

    // R8
    aluout_capture_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (alu_out == $past(alu_res)));
endmodule

bind mc_datapath mc_datapath_chk #(.W(32)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_sel     (pc_sel),
    .ir_wr      (ir_wr),
    .zero       (zero),
    .opcode     (opcode),
    .pc         (pc),
    .alu_out    (alu_out),
    .mem_rdata  (mem_rdata),
    .alu_res    (alu_res)
);

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;
    localparam int WORDS = 256;
    localparam int MAW   = 8;

    typedef struct {
        logic       iord, mem_wr, ir_wr, pc_wr, pc_wr_cond, pc_sel, src_a;
        logic [1:0] src_b;
        logic [2:0] op;
        logic       reg_dst, mem_to_reg, reg_wr;
    } ctl_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iord = 0, mem_wr = 0, ir_wr = 0, pc_wr = 0, pc_wr_cond = 0, pc_sel = 0;
    logic alu_src_a = 0;
    logic [1:0] alu_src_b = 0;
    logic [2:0] alu_op = 0;
    logic reg_dst = 0, mem_to_reg = 0, reg_wr = 0, ld_en = 0;
    logic [MAW-1:0] ld_addr = 0;
    logic [31:0] ld_data = 0;
    logic [5:0] opcode, funct;
    logic zero;
    logic [31:0] pc, alu_out, mem_rdata;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_mem [WORDS];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc, m_ir, m_a, m_b, m_mdr, m_res;

    always #5 clk = ~clk;

    mc_datapath #(.MEM_WORDS(WORDS)) u_mc_datapath (
        .clk(clk), .rst(rst), .iord(iord), .mem_wr(mem_wr), .ir_wr(ir_wr),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_sel(pc_sel),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op),
        .reg_dst(reg_dst), .mem_to_reg(mem_to_reg), .reg_wr(reg_wr),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .opcode(opcode), .funct(funct), .zero(zero), .pc(pc),
        .alu_out(alu_out), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_sext(input logic [31:0] w);
        return {{16{w[15]}}, w[15:0]};
    endfunction

    function automatic logic [31:0] f_alu(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            3'd0: return a + b;
            3'd1: return a - b;
            3'd2: return a & b;
            3'd3: return a | b;
            3'd4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic ctl_t c_none();
        ctl_t c;
        c.iord = 0; c.mem_wr = 0; c.ir_wr = 0; c.pc_wr = 0; c.pc_wr_cond = 0;
        c.pc_sel = 0; c.src_a = 0; c.src_b = 0; c.op = 0;
        c.reg_dst = 0; c.mem_to_reg = 0; c.reg_wr = 0;
        return c;
    endfunction

    task automatic drive(input ctl_t c);
        iord = c.iord; mem_wr = c.mem_wr; ir_wr = c.ir_wr; pc_wr = c.pc_wr;
        pc_wr_cond = c.pc_wr_cond; pc_sel = c.pc_sel; alu_src_a = c.src_a;
        alu_src_b = c.src_b; alu_op = c.op; reg_dst = c.reg_dst;
        mem_to_reg = c.mem_to_reg; reg_wr = c.reg_wr;
    endtask

    // One datapath cycle: entered and left just after a falling edge.
    task automatic step(input ctl_t c);
        logic [31:0] addr, rd, oa, ob, res, a_n, b_n;
        logic z;
        logic [4:0] wa;
        drive(c);
        #1;
        addr = c.iord ? m_res : m_pc;
        rd = m_mem[addr[MAW+1:2]];
        oa = c.src_a ? m_a : m_pc;
        case (c.src_b)
            2'd0: ob = m_b;
            2'd1: ob = 32'd4;
            2'd2: ob = f_sext(m_ir);
            default: ob = f_sext(m_ir) << 2;
        endcase
        res = f_alu(c.op, oa, ob);
        z = (res == 32'd0);
        chk(zero == z, "R7 zero flag", {31'd0, zero}, {31'd0, z});
        chk(mem_rdata == rd, "R2 memory read word", mem_rdata, rd);
        @(posedge clk);
        a_n = m_rf[m_ir[25:21]];
        b_n = m_rf[m_ir[20:16]];
        if (c.mem_wr) m_mem[addr[MAW+1:2]] = m_b;
        if (c.reg_wr) begin
            wa = c.reg_dst ? m_ir[15:11] : m_ir[20:16];
            if (wa != 5'd0) m_rf[wa] = c.mem_to_reg ? m_mdr : m_res;
        end
        if (c.pc_wr || (c.pc_wr_cond && z)) m_pc = c.pc_sel ? m_res : res;
        if (c.ir_wr) m_ir = rd;
        m_mdr = rd;
        m_a = a_n;
        m_b = b_n;
        m_res = res;
        @(negedge clk);
        chk(pc == m_pc, "R9 pc update", pc, m_pc);
        chk(alu_out == m_res, "R8 result register", alu_out, m_res);
        chk(opcode == m_ir[31:26], "R3 opcode field", {26'd0, opcode}, {26'd0, m_ir[31:26]});
        chk(funct == m_ir[5:0], "R3 funct field", {26'd0, funct}, {26'd0, m_ir[5:0]});
    endtask

    task automatic fetch();
        ctl_t c = c_none();
        c.ir_wr = 1; c.src_b = 2'd1; c.pc_wr = 1;
        step(c);
    endtask

    task automatic decode();
        ctl_t c = c_none();
        c.src_b = 2'd3;
        step(c);
    endtask

    task automatic exec_addr(input logic wr, input logic rdmem);
        ctl_t c = c_none();
        c.src_a = 1; c.src_b = 2'd2;
        if (wr || rdmem) begin c.iord = 1; c.mem_wr = wr; end
        step(c);
    endtask

    task automatic exec_rr(input logic [2:0] op, input logic br);
        ctl_t c = c_none();
        c.src_a = 1; c.op = op; c.pc_wr_cond = br; c.pc_sel = br;
        step(c);
    endtask

    task automatic wb(input logic dst_rd, input logic from_mdr);
        ctl_t c = c_none();
        c.reg_wr = 1; c.reg_dst = dst_rd; c.mem_to_reg = from_mdr;
        step(c);
    endtask

    task automatic mem_load(input int idx, input logic [31:0] v, input logic also_store);
        ld_en = 1; ld_addr = MAW'(idx); ld_data = v; mem_wr = also_store;
        @(posedge clk);
        m_mem[idx] = v;
        @(negedge clk);
        ld_en = 0; mem_wr = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        ctl_t c;
        void'($urandom(32'd20240607));
        @(negedge clk);
        // R13: fill memory while reset is held
        for (int i = 0; i < WORDS; i++) mem_load(i, $urandom, 1'b0);
        mem_load(1, 32'h00A03820, 1'b0);
        mem_load(2, 32'h8C000040, 1'b0);
        mem_load(3, 32'h00070020, 1'b0);
        mem_load(4, 32'hAC070044, 1'b0);
        mem_load(5, 32'h10E70003, 1'b0);
        mem_load(9, 32'h10E00003, 1'b0);
        mem_load(16, 32'h00000001, 1'b0);
        mem_load(18, 32'h12345678, 1'b0);
        // R13: load port wins over a simultaneous store to the same word
        mem_load(0, 32'h8C050048, 1'b1);
        m_pc = 0; m_ir = 0; m_a = 0; m_b = 0; m_mdr = 0; m_res = 0;
        for (int r = 0; r < 32; r++) m_rf[r] = 0;
        rst = 0;
        #1;
        // R1 reset state
        chk(pc == 32'd0, "R1 pc after reset", pc, 32'd0);
        chk(alu_out == 32'd0, "R1 result register after reset", alu_out, 32'd0);
        chk(opcode == 6'd0, "R1 instruction register after reset", {26'd0, opcode}, 32'd0);
        chk(zero == 1'b1, "R1 zero with cleared operands", {31'd0, zero}, 32'd1);
        @(negedge clk);

        // load r5 from word 18
        fetch();
        chk(opcode == 6'h23, "R13 load-port word fetched", {26'd0, opcode}, 32'h23);
        chk(pc == 32'd4, "R9 pc plus four", pc, 32'd4);
        decode();
        chk(alu_out == 32'h124, "R6 shifted immediate target", alu_out, 32'h124);
        exec_addr(1'b0, 1'b0);
        chk(alu_out == 32'h48, "R6 sign-extended immediate", alu_out, 32'h48);
        exec_addr(1'b0, 1'b1);
        chk(mem_rdata == 32'h12345678, "R2 data address from result register", mem_rdata, 32'h12345678);
        wb(1'b0, 1'b1);
        // r7 = r5 + r0
        fetch(); decode(); exec_rr(3'd0, 1'b0);
        chk(alu_out == 32'h12345678, "R4 loaded word reached register", alu_out, 32'h12345678);
        wb(1'b1, 1'b0);
        // try to write r0 with 1
        fetch(); decode(); exec_addr(1'b0, 1'b1); wb(1'b0, 1'b1);
        // r0 + r7
        fetch(); decode(); exec_rr(3'd0, 1'b0);
        chk(alu_out == 32'h12345678, "R11 register zero unchanged", alu_out, 32'h12345678);
        chk(alu_out == 32'h12345678, "R10 rd field write of r7", alu_out, 32'h12345678);
        chk(alu_out == 32'h12345678, "R5 operand B from rt", alu_out, 32'h12345678);
        // store r7 to word 17
        fetch(); decode(); exec_addr(1'b0, 1'b0); exec_addr(1'b1, 1'b0);
        chk(mem_rdata == 32'h12345678, "R12 stored operand B", mem_rdata, 32'h12345678);
        // taken branch
        fetch(); decode();
        chk(alu_out == 32'd36, "R6 branch target", alu_out, 32'd36);
        exec_rr(3'd1, 1'b1);
        chk(pc == 32'd36, "R9 taken conditional write", pc, 32'd36);
        // not-taken branch
        fetch(); decode(); exec_rr(3'd1, 1'b1);
        chk(pc == 32'd40, "R9 not-taken holds pc", pc, 32'd40);

        // random control patterns, checked against the model
        for (int n = 0; n < 3000; n++) begin
            c.iord = 1'($urandom); c.mem_wr = ($urandom % 4) == 0;
            c.ir_wr = ($urandom % 3) == 0; c.pc_wr = ($urandom % 4) == 0;
            c.pc_wr_cond = 1'($urandom); c.pc_sel = 1'($urandom);
            c.src_a = 1'($urandom); c.src_b = 2'($urandom);
            c.op = 3'($urandom); c.reg_dst = 1'($urandom);
            c.mem_to_reg = 1'($urandom); c.reg_wr = 1'($urandom);
            step(c);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule